// File: doc/BRIEF.md
# Audio DAC Anti-Pop Ramp Sequencer

This block brings an audio output path up and down without an audible click. The path is a DAC, a mute-release control, a power amplifier and a volume field. When the DAC output jumps suddenly, or the amplifier switches on while the DAC sits at a rail, the speaker produces a pop. The sequencer avoids this. On a start request it turns the DAC on at code zero, with the amplifier off and the volume at zero. It then walks the DAC code up one LSB at a time, with a fixed dwell of about 10 µs per step, until the code reaches mid-scale. Only then does it switch the amplifier on and open the volume.

While the path is up, the block reports ready. It passes audio samples and the requested volume straight to the path, each through one register stage. A stop request reverses the sequence. The volume drops to zero and the amplifier switches off while the DAC holds mid-scale. The code then walks down to zero at the same pace. Finally the mute is re-engaged and, one cycle later, the DAC is switched off. Requests that arrive while a ramp runs are ignored, with one exception: a stop that arrives during ramp-up is remembered and carried out once ramp-up has finished.

Top module: `audio_ramp_seq`

## Requirements
- R1: While reset is high and after reset, every output is 0. This covers the DAC word, all enables, mute-release, the volume, ready and busy.
- R2: One cycle after the sequencer leaves the off state on a start request, the outputs are: DAC enable 1, mute-release 1, amplifier enable 0, volume 0, DAC word 0, busy 1.
- R3: During ramp-up the DAC word changes only by +1. It visits every code from 1 up to mid-scale 2^(DAC_W-1), which is 0x8000 at the default width.
- R4: While a ramp runs, consecutive DAC-word changes are exactly DWELL = CLK_HZ/100000 clock cycles apart, which is 10 µs (80 cycles at 8 MHz).
- R5: The amplifier enable rises in the first cycle in which the DAC word shows mid-scale. While it is high, DAC enable and mute-release are high as well.
- R6: One cycle after the amplifier enable rises, ready is 1 and busy is 0. While ready, the volume output and the DAC word follow the volume and sample inputs with one cycle of latency. A nonzero volume appears only while ready.
- R7: One cycle after a stop is accepted, the outputs are: amplifier enable 0, volume 0, DAC word mid-scale, ready 0, busy 1. The word then steps by -1 down to 0, with the same dwell as in R4.
- R8: After the word reaches 0, mute-release clears first while the DAC enable stays 1. In the following cycle the DAC enable and busy both clear.
- R9: A start request has no effect while ready or while a ramp runs. A stop request has no effect during ramp-down or while off.
- R10: A stop request that arrives during ramp-up is held. Ready is shown for exactly one cycle, and then ramp-down begins without any further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Power-up request |
| stop_i | input | 1 | Power-down request |
| vol_i | input | VOL_W | Requested volume, applied while ready |
| sample_i | input | DAC_W | Audio sample, passed to the DAC while ready |
| dac_data_o | output | DAC_W | DAC code |
| dac_en_o | output | 1 | DAC enable |
| amp_en_o | output | 1 | Power amplifier enable |
| unmute_o | output | 1 | Speaker mute release |
| vol_o | output | VOL_W | Volume field to the path |
| ready_o | output | 1 | Path is up and passing samples |
| busy_o | output | 1 | A ramp or an enable step is in progress |

## Verification
The scoreboard predicts every DAC code of each ramp and the spacing between codes. A ramp that skipped a code, stopped one short of mid-scale, or ran with a dwell that was off by one would cause a mismatch. The bench checks that the amplifier turns on in the cycle mid-scale first appears, and that turn-off happens in two separate steps: mute first, then DAC off. A design that enabled the amplifier early, or dropped both controls at once, would fail these checks. Start and stop requests are sent during both ramps and while ready, so a design that restarted or aborted a ramp would be caught. A stop sent during ramp-up must produce a single ready cycle followed by an automatic ramp-down. A design that dropped the deferred stop would hang in ready and never ramp down.

// File: rtl/audio_ramp_pkg.sv
package audio_ramp_pkg;

  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_UP_INIT = 4'd1,
    ST_UP_RAMP = 4'd2,
    ST_UP_AMP  = 4'd3,
    ST_READY   = 4'd4,
    ST_DN_PREP = 4'd5,
    ST_DN_RAMP = 4'd6,
    ST_DN_MUTE = 4'd7
  } seq_state_e;

  localparam int unsigned STEPS_PER_SEC = 100_000;

endpackage

// File: rtl/ramp_dwell_timer.sv
module ramp_dwell_timer #(
  parameter int unsigned DWELL = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R4: the timer never runs past its terminal count
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/ramp_code_counter.sv
module ramp_code_counter #(
  parameter int unsigned DAC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [DAC_W-1:0] code_o
);
  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

  logic [DAC_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)        code_q <= '0;
    else if (inc_i) code_q <= code_q + 1'b1;
    else if (dec_i) code_q <= code_q - 1'b1;
  end

  assign code_o = code_q;

  // R3: the ramp code stays inside zero..mid-scale
  assert_code_bound_R3: assert property (@(posedge clk) disable iff (rst)
    code_q <= MID);
  // R3/R7: never asked to move both ways at once
  assert_one_dir_R3: assert property (@(posedge clk) disable iff (rst)
    !(inc_i && dec_i));
endmodule

// File: rtl/ramp_seq_fsm.sv
module ramp_seq_fsm
  import audio_ramp_pkg::*;
#(
  parameter int unsigned DAC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [DAC_W-1:0] code_i,
  output seq_state_e       state_o,
  output logic             tmr_run_o,
  output logic             inc_o,
  output logic             dec_o
);
  localparam logic [DAC_W-1:0] MID    = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic [DAC_W-1:0] MID_M1 = MID - 1'b1;
  localparam logic [DAC_W-1:0] ONE    = {{(DAC_W-1){1'b0}}, 1'b1};

  seq_state_e state_q, state_d;
  logic       stop_pend_q;
  logic       in_rampup;

  assign in_rampup = (state_q == ST_UP_INIT) || (state_q == ST_UP_RAMP) ||
                     (state_q == ST_UP_AMP);

  always_comb begin
    state_d   = state_q;
    tmr_run_o = 1'b0;
    inc_o     = 1'b0;
    dec_o     = 1'b0;
    case (state_q)
      ST_OFF:     if (start_i) state_d = ST_UP_INIT;
      ST_UP_INIT: state_d = ST_UP_RAMP;
      ST_UP_RAMP: begin
        tmr_run_o = 1'b1;
        if (tick_i) begin
          inc_o = 1'b1;
          if (code_i == MID_M1) state_d = ST_UP_AMP;
        end
      end
      ST_UP_AMP:  state_d = ST_READY;
      ST_READY:   if (stop_i || stop_pend_q) state_d = ST_DN_PREP;
      ST_DN_PREP: state_d = ST_DN_RAMP;
      ST_DN_RAMP: begin
        tmr_run_o = 1'b1;
        if (tick_i) begin
          dec_o = 1'b1;
          if (code_i == ONE) state_d = ST_DN_MUTE;
        end
      end
      ST_DN_MUTE: state_d = ST_OFF;
      default:    state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      stop_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_READY)       stop_pend_q <= 1'b0;
      else if (in_rampup && stop_i)  stop_pend_q <= 1'b1;
    end
  end

  assign state_o = state_q;

  // R4: dwell ticks only arrive while a ramp runs
  assert_tick_in_ramp_R4: assert property (@(posedge clk) disable iff (rst)
    tick_i |-> (state_q == ST_UP_RAMP || state_q == ST_DN_RAMP));
  // R10: a held stop is always consumed by the next ready cycle
  assert_pend_consumed_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && stop_pend_q) |=> state_q == ST_DN_PREP);
  // R5: amplifier stage is entered only with the code at mid-scale
  assert_amp_at_mid_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP_AMP) |-> code_i == MID);
endmodule

// File: rtl/audio_ramp_seq.sv
module audio_ramp_seq
  import audio_ramp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 8_000_000,
  parameter int unsigned DAC_W  = 16,
  parameter int unsigned VOL_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [VOL_W-1:0] vol_i,
  input  logic [DAC_W-1:0] sample_i,
  output logic [DAC_W-1:0] dac_data_o,
  output logic             dac_en_o,
  output logic             amp_en_o,
  output logic             unmute_o,
  output logic [VOL_W-1:0] vol_o,
  output logic             ready_o,
  output logic             busy_o
);
  localparam int unsigned DWELL_RAW = CLK_HZ / STEPS_PER_SEC;
  localparam int unsigned DWELL     = (DWELL_RAW > 0) ? DWELL_RAW : 1;
  localparam logic [DAC_W-1:0] MID  = {1'b1, {(DAC_W-1){1'b0}}};

  seq_state_e       state;
  logic             tmr_run, tick, inc, dec;
  logic [DAC_W-1:0] code;

  ramp_dwell_timer #(.DWELL(DWELL)) u_timer (
    .clk(clk), .rst(rst), .run_i(tmr_run), .tick_o(tick)
  );

  ramp_code_counter #(.DAC_W(DAC_W)) u_code (
    .clk(clk), .rst(rst), .inc_i(inc), .dec_i(dec), .code_o(code)
  );

  ramp_seq_fsm #(.DAC_W(DAC_W)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .tick_i(tick), .code_i(code), .state_o(state),
    .tmr_run_o(tmr_run), .inc_o(inc), .dec_o(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_data_o <= '0;
      dac_en_o   <= 1'b0;
      amp_en_o   <= 1'b0;
      unmute_o   <= 1'b0;
      vol_o      <= '0;
      ready_o    <= 1'b0;
      busy_o     <= 1'b0;
    end else begin
      dac_data_o <= (state == ST_READY) ? sample_i : code;
      dac_en_o   <= (state != ST_OFF);
      amp_en_o   <= (state == ST_UP_AMP) || (state == ST_READY);
      unmute_o   <= (state != ST_OFF) && (state != ST_DN_MUTE);
      vol_o      <= (state == ST_READY) ? vol_i : '0;
      ready_o    <= (state == ST_READY);
      busy_o     <= (state != ST_OFF) && (state != ST_READY);
    end
  end

  // R5: amplifier comes on exactly with mid-scale on the DAC
  assert_amp_rise_mid_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_en_o) |-> dac_data_o == MID);
  // R5: amplifier never runs without the DAC and mute release
  assert_amp_path_R5: assert property (@(posedge clk) disable iff (rst)
    amp_en_o |-> (dac_en_o && unmute_o));
  // R3 and R7: during a ramp the word moves by one LSB at most
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && dac_data_o != $past(dac_data_o)) |->
      (dac_data_o == $past(dac_data_o) + 1'b1 ||
       dac_data_o == $past(dac_data_o) - 1'b1));
  // R8: DAC turns off at zero, after mute was re-engaged a cycle earlier
  assert_off_order_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_en_o) |-> (!unmute_o && !$past(unmute_o) && dac_data_o == '0));
  // R6: volume opens only while ready
  assert_vol_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (vol_o != '0) |-> ready_o);
  // R6: ready and busy are exclusive
  assert_ready_busy_R6: assert property (@(posedge clk) disable iff (rst)
    !(ready_o && busy_o));
endmodule

// File: tb/audio_ramp_seq_tb.sv
module audio_ramp_seq_tb;
  localparam int unsigned CLK_HZ = 300_000;
  localparam int unsigned DW     = 6;
  localparam int unsigned VW     = 7;
  localparam int unsigned DWELL  = CLK_HZ / 100_000;
  localparam int          MID    = 1 << (DW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, stop_i = 1'b0;
  logic [VW-1:0] vol_i = '0;
  logic [DW-1:0] sample_i = '0;
  logic [DW-1:0] dac_data_o;
  logic          dac_en_o, amp_en_o, unmute_o, ready_o, busy_o;
  logic [VW-1:0] vol_o;

  typedef struct packed { logic [DW-1:0] code; logic chk_gap; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  audio_ramp_seq #(.CLK_HZ(CLK_HZ), .DAC_W(DW), .VOL_W(VW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .vol_i(vol_i), .sample_i(sample_i), .dac_data_o(dac_data_o),
    .dac_en_o(dac_en_o), .amp_en_o(amp_en_o), .unmute_o(unmute_o),
    .vol_o(vol_o), .ready_o(ready_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_up();
    for (int c = 1; c <= MID; c++) q.push_back({DW'(c), (c > 1)});
  endtask

  task automatic push_down();
    q.push_back({DW'(MID), 1'b0});
    for (int c = MID - 1; c >= 0; c--) q.push_back({DW'(c), (c < MID - 1)});
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  // Monitor: scoreboard of ramp codes and step spacing (R3, R4, R7)
  logic [DW-1:0] prev_data;
  int            gap;
  always @(negedge clk) begin
    if (rst) begin
      prev_data <= '0;
      gap       <= 0;
    end else begin
      if (dac_data_o != prev_data) begin
        if (busy_o) begin
          if (q.size() == 0) chk(1'b0, "R3", "unexpected code", dac_data_o, -1);
          else begin
            exp_t e;
            e = q.pop_front();
            chk(dac_data_o == e.code, "R3/R7", "ramp code", dac_data_o, e.code);
            if (e.chk_gap) chk(gap + 1 == DWELL, "R4", "step dwell", gap + 1, DWELL);
          end
        end
        gap <= 0;
      end else gap <= gap + 1;
      prev_data <= dac_data_o;
    end
  end

  initial begin
    repeat (100_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(dac_data_o == 0 && !dac_en_o && !amp_en_o && !unmute_o && vol_o == 0
        && !ready_o && !busy_o, "R1", "reset outputs", dac_en_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!dac_en_o && !busy_o, "R1", "idle after reset", busy_o, 0);

    // Full up/down cycle
    vol_i = 7'h55; sample_i = 6'd9;
    push_up();
    pulse_start();
    @(negedge clk);
    chk(dac_en_o && unmute_o && !amp_en_o && vol_o == 0 && dac_data_o == 0
        && busy_o, "R2", "start outputs", {dac_en_o, unmute_o, amp_en_o, busy_o}, 4'b1101);
    repeat (10) @(negedge clk);
    chk(!amp_en_o, "R5", "amp off mid-ramp", amp_en_o, 0);
    pulse_start();   // ignored during ramp-up (R9)
    while (!amp_en_o) @(negedge clk);
    chk(dac_data_o == MID, "R5", "data at amp rise", dac_data_o, MID);
    chk(!ready_o && busy_o, "R5", "ready not yet", ready_o, 0);
    @(negedge clk);
    chk(ready_o && !busy_o, "R6", "ready after amp", ready_o, 1);
    chk(vol_o == 7'h55, "R6", "volume loaded", vol_o, 7'h55);
    chk(dac_data_o == 9, "R6", "sample passthrough", dac_data_o, 9);
    chk(q.size() == 0, "R3", "up codes consumed", q.size(), 0);
    vol_i = 7'h12; sample_i = 6'd11;
    @(negedge clk);
    chk(vol_o == 7'h12 && dac_data_o == 11, "R6", "follow inputs", dac_data_o, 11);
    pulse_start();   // ignored while ready (R9)
    repeat (3) @(negedge clk);
    chk(ready_o && amp_en_o && dac_data_o == 11, "R9", "start while ready", ready_o, 1);

    push_down();
    pulse_stop();
    @(negedge clk);
    chk(!amp_en_o && vol_o == 0 && dac_data_o == MID && !ready_o && busy_o
        && dac_en_o && unmute_o, "R7", "stop prep", dac_data_o, MID);
    repeat (10) @(negedge clk);
    pulse_start();   // ignored during ramp-down (R9)
    pulse_stop();
    while (unmute_o) @(negedge clk);
    chk(dac_en_o && dac_data_o == 0 && busy_o, "R8", "mute first", dac_en_o, 1);
    @(negedge clk);
    chk(!dac_en_o && !busy_o, "R8", "dac off next", dac_en_o, 0);
    chk(q.size() == 0, "R7", "down codes consumed", q.size(), 0);
    repeat (20) @(negedge clk);
    chk(!dac_en_o && !busy_o && !ready_o, "R9", "no restart", dac_en_o, 0);
    pulse_stop();    // ignored while off (R9)
    repeat (3) @(negedge clk);
    chk(!dac_en_o && !busy_o, "R9", "stop while off", busy_o, 0);

    // Deferred stop (R10)
    push_up();
    push_down();
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_stop();
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    chk(!ready_o && busy_o && !amp_en_o, "R10", "one ready cycle", ready_o, 0);
    while (dac_en_o) @(negedge clk);
    chk(!unmute_o && !busy_o && dac_data_o == 0, "R10", "auto ramp-down", busy_o, 0);
    chk(q.size() == 0, "R10", "all codes consumed", q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule